// File: doc/BRIEF.md
# Six-Channel Sampling Converter Readout Sequencer

This block sits on the host side of a serial analog-to-digital converter that samples six inputs at the same instant. When a start request arrives, it drives one convert pulse, which freezes all inputs. It then produces a burst of serial clocks and shifts in one 16-clock frame per enabled channel. The 14-bit result from each frame is written into a register for that channel. When the burst ends, a done pulse is raised and a valid flag is set for each channel that was read.

When the sequencer is idle, it can also drive the converter's low-power protocol. A nap request produces two convert pulses while the serial clock stays low. A sleep request produces four such pulses. A wake request produces a single serial clock pulse. The sequencer keeps track of which power state the converter is in. If a conversion is requested while the converter is powered down, the wake pulse is issued first.

All line timing comes from one programmable phase length. A phase is `div_i + 1` system clocks. Every high or low level on the convert line and on the serial clock lasts exactly one phase.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A request (start or power) is accepted only in a cycle where `busy_o` is low, and `busy_o` is high from the next cycle. Start and power requests made while `busy_o` is high have no effect on the outputs.
- R2: After an accepted start with the converter active, `conv_o` is high for one phase and then low for one phase. A phase is `div_i + 1` clocks, and `div_i` is captured at acceptance.
- R3: After the convert pulse, `sck_o` produces 16 pulses per active channel, each high for one phase and then low for one phase. `conv_o` and `sck_o` are low whenever `busy_o` is low.
- R4: The number of active channels is `chan_sel_i + 1` for codes 0 to 5, and six for codes 6 and 7. The code is captured at acceptance.
- R5: `sdo_i` is sampled in the last clock of each high phase of `sck_o`. The first 14 bits of frame k form the result for channel k, MSB first, at `result_o[k*14 +: 14]`. The last two bits of every frame are discarded.
- R6: `done_o` is high for one clock, in the cycle after the final low phase, and `busy_o` falls in the following cycle. `valid_o` is cleared in the cycle after a start is accepted. Bits 0 to N-1 of `valid_o` are set together with `done_o`. The results of inactive channels keep their earlier values.
- R7: `pwr_req_i` codes: 1 (nap) gives two `conv_o` pulses with `sck_o` low; 2 (sleep) gives four such pulses; 3 (wake) gives one `sck_o` pulse; 0 does nothing. Start wins when both are requested in the same idle cycle.
- R8: `pwr_o` reads 0 for active, 1 for nap and 2 for sleep. It takes its new value in the cycle the power pattern ends, when `busy_o` falls.
- R9: A start accepted while `pwr_o` is non-zero first drives one `sck_o` pulse (one phase high, one phase low) and then the convert pulse. `pwr_o` becomes 0 when the convert pulse begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request |
| chan_sel_i | input | 3 | Active channel count code |
| div_i | input | 8 | Phase length minus one, in system clocks |
| pwr_req_i | input | 2 | Power request: 0 none, 1 nap, 2 sleep, 3 wake |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert line |
| sck_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-readout pulse |
| pwr_o | output | 2 | Tracked converter power state |
| valid_o | output | 6 | Per-channel result valid |
| result_o | output | 84 | Six 14-bit results, channel 0 in the low bits |

## Verification
The assertions assume that `start_i` and `pwr_req_i` are synchronous to `clk_i`. They also assume that any change in `valid_o` comes only from the sequencer's own accept or completion events. They rely on the convert line and the serial clock never being driven together.

The stimulus changes every input half a cycle away from the sampling edge. It drives `sdo_i` from a converter model that moves to a new bit only on a rising `sck_o`. It deliberately holds start and power requests high while a sequence is running, to confirm that those requests are ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WAKE_HI, ST_WAKE_LO, ST_CONV_HI, ST_CONV_LO,
    ST_SCK_HI, ST_SCK_LO, ST_PD_HI, ST_PD_LO, ST_DONE
  } seq_st_e;

  typedef enum logic [1:0] {PWR_ON = 2'd0, PWR_NAP = 2'd1, PWR_SLEEP = 2'd2} pwr_e;
  typedef enum logic [1:0] {REQ_NONE = 2'd0, REQ_NAP = 2'd1, REQ_SLEEP = 2'd2, REQ_WAKE = 2'd3} pwr_req_e;

  localparam int unsigned NAP_PULSES   = 2;
  localparam int unsigned SLEEP_PULSES = 4;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, cnt_q;

  assign tick_o = run_i && (cnt_q == div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load_i) div_q <= div_i;
      if (!run_i || tick_o) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx #(
  parameter int CH_NUM = 6,
  parameter int RES_W  = 14,
  localparam int CNT_W = $clog2(CH_NUM + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    shift_i,
  input  logic                    sdo_i,
  input  logic                    store_i,
  input  logic                    fin_i,
  input  logic [CNT_W-1:0]        frm_i,
  input  logic [CNT_W-1:0]        n_act_i,
  output logic [CH_NUM-1:0]       valid_o,
  output logic [CH_NUM*RES_W-1:0] result_o
);
  logic [RES_W-1:0]  shift_q;
  logic [RES_W-1:0]  res_q [CH_NUM];
  logic [CH_NUM-1:0] valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else if (shift_i) shift_q <= {shift_q[RES_W-2:0], sdo_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int c = 0; c < CH_NUM; c++) res_q[c] <= '0;
    end else begin
      if (clr_i) valid_q <= '0;
      for (int c = 0; c < CH_NUM; c++) begin
        if (store_i && (frm_i == CNT_W'(c))) res_q[c] <= shift_q;
        if (fin_i) valid_q[c] <= (CNT_W'(c) < n_act_i);
      end
    end
  end

  assign valid_o = valid_q;

  for (genvar c = 0; c < CH_NUM; c++) begin : g_pack
    assign result_o[c*RES_W +: RES_W] = res_q[c];
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_NUM    = 6,
  parameter int RES_W     = 14,
  parameter int FRAME_LEN = 16,
  parameter int SEL_W     = 3,
  localparam int CNT_W    = $clog2(CH_NUM + 1),
  localparam int BIT_W    = $clog2(FRAME_LEN),
  localparam int PD_W     = $clog2(SLEEP_PULSES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       pwr_req_i,
  input  logic             tick_i,
  output logic             conv_o,
  output logic             sck_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             run_o,
  output logic             load_o,
  output logic             clr_o,
  output logic             shift_o,
  output logic             store_o,
  output logic             fin_o,
  output logic [CNT_W-1:0] frm_o,
  output logic [CNT_W-1:0] n_act_o,
  output logic [1:0]       pwr_o
);
  seq_st_e          st_q;
  pwr_e             pwr_q, pd_tgt_q;
  logic [BIT_W-1:0] bit_q;
  logic [CNT_W-1:0] frm_q, n_act_q, n_act_d;
  logic [PD_W-1:0]  pd_q, pd_last;
  logic             conv_after_q, idle;

  assign idle = (st_q == ST_IDLE);

  always_comb begin
    if (int'(sel_i) >= CH_NUM - 1) n_act_d = CNT_W'(CH_NUM);
    else                           n_act_d = CNT_W'(sel_i) + 1'b1;
  end

  assign pd_last = (pd_tgt_q == PWR_SLEEP) ? PD_W'(SLEEP_PULSES - 1) : PD_W'(NAP_PULSES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      pwr_q        <= PWR_ON;
      pd_tgt_q     <= PWR_NAP;
      bit_q        <= '0;
      frm_q        <= '0;
      n_act_q      <= CNT_W'(1);
      pd_q         <= '0;
      conv_after_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            n_act_q      <= n_act_d;
            bit_q        <= '0;
            frm_q        <= '0;
            conv_after_q <= 1'b1;
            st_q         <= (pwr_q != PWR_ON) ? ST_WAKE_HI : ST_CONV_HI;
          end else begin
            case (pwr_req_i)
              REQ_NAP:   begin pd_tgt_q <= PWR_NAP;   pd_q <= '0; st_q <= ST_PD_HI; end
              REQ_SLEEP: begin pd_tgt_q <= PWR_SLEEP; pd_q <= '0; st_q <= ST_PD_HI; end
              REQ_WAKE:  begin conv_after_q <= 1'b0; st_q <= ST_WAKE_HI; end
              default: ;
            endcase
          end
        end
        ST_WAKE_HI: if (tick_i) st_q <= ST_WAKE_LO;
        ST_WAKE_LO: if (tick_i) begin
          pwr_q <= PWR_ON;
          st_q  <= conv_after_q ? ST_CONV_HI : ST_IDLE;
        end
        ST_CONV_HI: if (tick_i) st_q <= ST_CONV_LO;
        ST_CONV_LO: if (tick_i) st_q <= ST_SCK_HI;
        ST_SCK_HI:  if (tick_i) st_q <= ST_SCK_LO;
        ST_SCK_LO: if (tick_i) begin
          if (bit_q == BIT_W'(FRAME_LEN - 1)) begin
            bit_q <= '0;
            if (frm_q == n_act_q - 1'b1) st_q <= ST_DONE;
            else begin
              frm_q <= frm_q + 1'b1;
              st_q  <= ST_SCK_HI;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
            st_q  <= ST_SCK_HI;
          end
        end
        ST_PD_HI: if (tick_i) st_q <= ST_PD_LO;
        ST_PD_LO: if (tick_i) begin
          if (pd_q == pd_last) begin
            pwr_q <= pd_tgt_q;
            st_q  <= ST_IDLE;
          end else begin
            pd_q <= pd_q + 1'b1;
            st_q <= ST_PD_HI;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_o  = (st_q == ST_CONV_HI) || (st_q == ST_PD_HI);
  assign sck_o   = (st_q == ST_SCK_HI) || (st_q == ST_WAKE_HI);
  assign busy_o  = !idle;
  assign done_o  = (st_q == ST_DONE);
  assign run_o   = !idle && !done_o;
  assign load_o  = idle && (start_i || (pwr_req_i != REQ_NONE));
  assign clr_o   = idle && start_i;
  // Capture on the last clock of the high phase; trailing frame bits are skipped.
  assign shift_o = tick_i && (st_q == ST_SCK_HI) && (int'(bit_q) < RES_W);
  assign store_o = tick_i && (st_q == ST_SCK_LO) && (bit_q == BIT_W'(FRAME_LEN - 1));
  assign fin_o   = store_o && (frm_q == n_act_q - 1'b1);
  assign frm_o   = frm_q;
  assign n_act_o = n_act_q;
  assign pwr_o   = pwr_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_NUM    = 6,
  parameter int RES_W     = 14,
  parameter int FRAME_LEN = 16,
  parameter int DIV_W     = 8,
  parameter int SEL_W     = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [SEL_W-1:0]        chan_sel_i,
  input  logic [DIV_W-1:0]        div_i,
  input  logic [1:0]              pwr_req_i,
  input  logic                    sdo_i,
  output logic                    conv_o,
  output logic                    sck_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [1:0]              pwr_o,
  output logic [CH_NUM-1:0]       valid_o,
  output logic [CH_NUM*RES_W-1:0] result_o
);
  localparam int CNT_W = $clog2(CH_NUM + 1);

  logic             tick, run, load, clr, shift, store, fin;
  logic [CNT_W-1:0] frm, n_act;

  adc_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .load_i(load),
    .div_i (div_i),
    .tick_o(tick)
  );

  adc_seq_fsm #(
    .CH_NUM(CH_NUM), .RES_W(RES_W), .FRAME_LEN(FRAME_LEN), .SEL_W(SEL_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .sel_i    (chan_sel_i),
    .pwr_req_i(pwr_req_i),
    .tick_i   (tick),
    .conv_o   (conv_o),
    .sck_o    (sck_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .run_o    (run),
    .load_o   (load),
    .clr_o    (clr),
    .shift_o  (shift),
    .store_o  (store),
    .fin_o    (fin),
    .frm_o    (frm),
    .n_act_o  (n_act),
    .pwr_o    (pwr_o)
  );

  adc_frame_rx #(.CH_NUM(CH_NUM), .RES_W(RES_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .shift_i (shift),
    .sdo_i   (sdo_i),
    .store_i (store),
    .fin_i   (fin),
    .frm_i   (frm),
    .n_act_i (n_act),
    .valid_o (valid_o),
    .result_o(result_o)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CH_NUM = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              conv_o,
  input logic              sck_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        pwr_o,
  input logic [CH_NUM-1:0] valid_o
);
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!conv_o && !sck_o)); // R3

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_o && sck_o)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R6

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && !conv_o && !sck_o)); // R6

  AST_VALID_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(valid_o) |-> (done_o || $past(start_i && !busy_o))); // R6

  AST_PWR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_o != 2'd3); // R8
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_NUM(CH_NUM)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .conv_o (conv_o),
  .sck_o  (sck_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .pwr_o  (pwr_o),
  .valid_o(valid_o)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CH = 6, RW = 14, FL = 16, DW = 8, SW = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdo = 1'b0;
  logic [SW-1:0] sel = '0;
  logic [DW-1:0] div = '0;
  logic [1:0] req = '0;
  logic conv_o, sck_o, busy_o, done_o;
  logic [1:0] pwr_o;
  logic [CH-1:0] valid_o;
  logic [CH*RW-1:0] result_o;

  always #5 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_sel_i(sel), .div_i(div),
    .pwr_req_i(req), .sdo_i(sdo), .conv_o(conv_o), .sck_o(sck_o), .busy_o(busy_o),
    .done_o(done_o), .pwr_o(pwr_o), .valid_o(valid_o), .result_o(result_o)
  );

  typedef struct packed {
    logic conv; logic sck; logic busy; logic done; logic [1:0] pwr; logic [CH-1:0] valid;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  logic [1:0] m_pwr = 2'd0;
  logic [CH-1:0] m_valid = '0;
  logic [RW-1:0] exp_res [CH];
  logic [15:0] word [CH];
  int nchk = 0, nerr = 0;
  int conv_rise = 0, sck_rise = 0, first_evt = 0, bit_idx = 0;
  logic conv_d = 1'b0, sck_d = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, expv, $time);
    end
  endtask

  task automatic push_n(input exp_t e, input int n);
    for (int i = 0; i < n; i++) q.push_back(e);
  endtask

  task automatic build_run();
    int ph = int'(div) + 1;
    int n = (int'(sel) >= CH - 1) ? CH : int'(sel) + 1;
    exp_t e;
    logic [CH-1:0] mask = '0;
    e.busy = 1'b1; e.done = 1'b0; e.valid = '0; e.conv = 1'b0;
    if (m_pwr != 2'd0) begin  // R9 wake first
      e.pwr = m_pwr; e.sck = 1'b1; push_n(e, ph);
      e.sck = 1'b0; push_n(e, ph);
    end
    e.pwr = 2'd0; e.sck = 1'b0;
    e.conv = 1'b1; push_n(e, ph);
    e.conv = 1'b0; push_n(e, ph);
    for (int i = 0; i < n * FL; i++) begin
      e.sck = 1'b1; push_n(e, ph);
      e.sck = 1'b0; push_n(e, ph);
    end
    for (int c = 0; c < n; c++) begin
      mask[c] = 1'b1;
      exp_res[c] = word[c][15:2];
    end
    e.valid = mask; e.done = 1'b1; push_n(e, 1);
    m_pwr = 2'd0;
    m_valid = mask;
  endtask

  task automatic build_pwr();
    int ph = int'(div) + 1;
    exp_t e;
    e.busy = 1'b1; e.done = 1'b0; e.valid = m_valid; e.pwr = m_pwr;
    e.conv = 1'b0; e.sck = 1'b0;
    if (req == 2'd3) begin
      e.sck = 1'b1; push_n(e, ph);
      e.sck = 1'b0; push_n(e, ph);
      m_pwr = 2'd0;
    end else begin
      for (int p = 0; p < ((req == 2'd2) ? 4 : 2); p++) begin
        e.conv = 1'b1; push_n(e, ph);
        e.conv = 1'b0; push_n(e, ph);
      end
      m_pwr = req;
    end
  endtask

  // Reference model: one queue entry per clock of an accepted sequence
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_pwr = 2'd0;
      m_valid = '0;
      for (int c = 0; c < CH; c++) exp_res[c] = '0;
    end else if (q.size() > 0) begin
      void'(q.pop_front());
    end else if (start) begin
      build_run();
    end else if (req != 2'd0) begin
      build_pwr();
    end
    cur.conv = 1'b0; cur.sck = 1'b0; cur.busy = 1'b0; cur.done = 1'b0;
    cur.pwr = m_pwr; cur.valid = m_valid;
    if (q.size() > 0) cur = q[0];
  end

  // Converter model and per-clock comparison
  always @(negedge clk) begin
    if (conv_o && !conv_d) begin
      conv_rise++;
      bit_idx = 0;
      if (first_evt == 0) first_evt = 2;
    end
    if (sck_o && !sck_d) begin
      sck_rise++;
      if (first_evt == 0) first_evt = 1;
      if (bit_idx / FL < CH) sdo <= word[bit_idx / FL][15 - (bit_idx % FL)];
      else sdo <= 1'b0;
      bit_idx++;
    end
    conv_d = conv_o;
    sck_d = sck_o;
    if (rst_n) begin
      chk(conv_o == cur.conv, "R2", "conv_o", conv_o, cur.conv);
      chk(sck_o == cur.sck, "R3", "sck_o", sck_o, cur.sck);
      chk(busy_o == cur.busy, "R1", "busy_o", busy_o, cur.busy);
      chk(done_o == cur.done, "R6", "done_o", done_o, cur.done);
      chk(pwr_o == cur.pwr, "R8", "pwr_o", pwr_o, cur.pwr);
      chk(valid_o == cur.valid, "R6", "valid_o", valid_o, cur.valid);
      if (!cur.busy || cur.done)
        for (int c = 0; c < CH; c++)
          chk(result_o[c*RW +: RW] == exp_res[c], "R5", "result", result_o[c*RW +: RW], exp_res[c]);
    end
  end

  task automatic clr_cnt();
    conv_rise = 0; sck_rise = 0; first_evt = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy_o);
    @(negedge clk);
  endtask

  task automatic new_words();
    for (int c = 0; c < CH; c++) word[c] = 16'($urandom);
  endtask

  task automatic kick(input logic [SW-1:0] s, input logic [DW-1:0] d);
    new_words();
    clr_cnt();
    @(negedge clk);
    start = 1'b1; sel = s; div = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic preq(input logic [1:0] r, input logic [DW-1:0] d);
    clr_cnt();
    @(negedge clk);
    req = r; div = d;
    @(negedge clk);
    req = 2'd0;
    wait_idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R1 watchdog expired actual=busy expected=idle");
    finish_run();
  end

  initial begin
    for (int c = 0; c < CH; c++) word[c] = '0;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1", "reset busy", busy_o, 0);
    chk(valid_o == '0, "R6", "reset valid", valid_o, 0);
    chk(pwr_o == 2'd0, "R8", "reset pwr", pwr_o, 0);
    chk({conv_o, sck_o} == 2'b00, "R3", "reset lines", {conv_o, sck_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    kick(3'd5, 8'd0); wait_idle();
    chk(sck_rise == 96, "R4", "six-channel sck count", sck_rise, 96);
    chk(conv_rise == 1, "R2", "convert pulses", conv_rise, 1);

    kick(3'd0, 8'd2); wait_idle();  // R6 inactive channels keep old results
    chk(sck_rise == 16, "R4", "one-channel sck count", sck_rise, 16);

    kick(3'd7, 8'd1); wait_idle();
    chk(sck_rise == 96, "R4", "code 7 clamps to six", sck_rise, 96);

    kick(3'd2, 8'd0);  // R1 requests during busy are ignored
    repeat (5) @(negedge clk);
    start = 1'b1; req = 2'd1;
    repeat (3) @(negedge clk);
    start = 1'b0; req = 2'd0;
    wait_idle();
    chk(conv_rise == 1, "R1", "no extra convert", conv_rise, 1);
    chk(pwr_o == 2'd0, "R1", "nap ignored while busy", pwr_o, 0);

    preq(2'd1, 8'd1);
    chk(conv_rise == 2 && sck_rise == 0, "R7", "nap pattern", conv_rise * 100 + sck_rise, 200);
    chk(pwr_o == 2'd1, "R8", "nap state", pwr_o, 1);

    kick(3'd3, 8'd1); wait_idle();
    chk(first_evt == 1, "R9", "wake before convert", first_evt, 1);
    chk(sck_rise == 65, "R9", "wake plus 64 clocks", sck_rise, 65);

    preq(2'd2, 8'd0);
    chk(conv_rise == 4 && sck_rise == 0, "R7", "sleep pattern", conv_rise * 100 + sck_rise, 400);
    chk(pwr_o == 2'd2, "R8", "sleep state", pwr_o, 2);

    preq(2'd3, 8'd2);
    chk(sck_rise == 1 && conv_rise == 0, "R7", "wake pattern", sck_rise * 100 + conv_rise, 100);
    chk(pwr_o == 2'd0, "R8", "wake state", pwr_o, 0);

    new_words(); clr_cnt();
    @(negedge clk);
    start = 1'b1; req = 2'd2; sel = 3'd1; div = 8'd0;
    @(negedge clk);
    start = 1'b0; req = 2'd0;
    wait_idle();
    chk(conv_rise == 1 && pwr_o == 2'd0, "R7", "start wins over sleep", conv_rise * 10 + pwr_o, 10);

    kick(3'd1, 8'd3);  // R2 divider captured at accept
    div = 8'd0;
    wait_idle();
    chk(sck_rise == 32, "R4", "two-channel sck count", sck_rise, 32);

    finish_run();
  end
endmodule